// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs single read and write transfers on an external 8-bit bus where the address and the data share one set of lines. An internal requester raises `req_i` with the address, the write data, a write flag, a memory-space select and a timing-mode flag. The block then places the address on the shared lines and qualifies it with an active-low address strobe. It floats the lines for one clock and frames the data with an active-low data strobe. When the transfer is done it returns a one-clock acknowledge and, for reads, the captured byte.

The direction line and the memory-space select are held steady for the whole transfer. A write drives its data across the full data-strobe window. A read leaves the lines undriven so that the external device can answer. An extended mode, chosen per transfer, keeps the data strobe low for two extra clocks. Every strobe and enable comes straight from a flip-flop. All timing is measured in internal clock periods.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset, `as_n_o`=1, `ds_n_o`=1, `ad_oe_o`=0, `ack_o`=0, `rw_o`=1 and `dm_n_o`=1.
- R2: A request is accepted on the first rising edge where the block is idle, `req_i`=1 and `ack_o`=0. For the next two clocks `ad_oe_o`=1 and `ad_out_o` equals the request address. `as_n_o` is 0 in the first of these clocks and 1 in the second, so the address is still driven when the strobe rises.
- R3: Exactly one clock separates the address phase from the data strobe. In that clock `ad_oe_o`=0 and both strobes are 1.
- R4: From the first address clock through the clock after the data strobe rises, `rw_o` holds 1 for a read and 0 for a write. Over the same span, `dm_n_o` holds 0 when `dmem_i` was 1 and holds 1 otherwise. When idle, both are 1.
- R5: On a read, `ad_oe_o` is 0 for the whole data-strobe window. The value on `ad_in_i` during the last strobe clock appears on `rdata_o` by the time `ack_o` is high.
- R6: On a write, `ad_oe_o`=1 and `ad_out_o` equals the write data in every clock that the data strobe is low, and in the clock just after it rises.
- R7: `ds_n_o` is low for one clock when `ext_i`=0 at acceptance and for three clocks when `ext_i`=1.
- R8: `ack_o` is high for exactly one clock. With acceptance at edge 0, `ack_o` rises at edge 5 in normal mode and at edge 7 in extended mode.
- R9: `as_n_o` and `ds_n_o` are never low at the same time.
- R10: With `req_i` held at 1, a new transfer is not accepted while `ack_o` is high. Back-to-back address strobes therefore start 7 clocks apart in normal mode and 9 clocks apart in extended mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transfer request |
| wr_i | input | 1 | 1 = write, 0 = read |
| dmem_i | input | 1 | 1 = data-memory space |
| ext_i | input | 1 | 1 = extended data strobe |
| addr_i | input | 8 | Transfer address |
| wdata_i | input | 8 | Write data |
| ack_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Read data |
| ad_out_o | output | 8 | Shared-line output value |
| ad_oe_o | output | 1 | Shared-line output enable |
| ad_in_i | input | 8 | Shared-line input value |
| as_n_o | output | 1 | Address strobe, active low |
| ds_n_o | output | 1 | Data strobe, active low |
| rw_o | output | 1 | Direction, 1 = read, 0 = write |
| dm_n_o | output | 1 | Data-memory select, active low |

## Verification
The assertions check on every cycle the orderings that hold for any transfer. The address is driven when the address strobe rises. The lines float in the clock before the data strobe falls. Direction and space select do not change while the data strobe is low or as it rises. The strobes never overlap, read data phases are undriven, write data phases are driven, and the acknowledge lasts one clock. Only the bench scenarios can show the exact clock counts of each phase in both timing modes, the values carried on the lines, and the byte returned by a read. They also show end-to-end write-then-read agreement with an external memory model in both address spaces, and the restart spacing when requests are held.

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl #(
  parameter int DW        = 8,
  parameter int EXT_EXTRA = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic          dmem_i,
  input  logic          ext_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] ad_out_o,
  output logic          ad_oe_o,
  input  logic [DW-1:0] ad_in_i,
  output logic          as_n_o,
  output logic          ds_n_o,
  output logic          rw_o,
  output logic          dm_n_o
);

  localparam int CW = (EXT_EXTRA > 0) ? $clog2(EXT_EXTRA + 1) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_LATCH, S_FLOAT, S_DATA, S_REL} st_t;

  st_t           st, nx;
  logic [CW-1:0] cnt;
  logic          wr_r, ext_r;
  logic [DW-1:0] wdata_r;

  wire start = (st == S_IDLE) && req_i && !ack_o;
  wire last  = (st == S_DATA) && (cnt == '0);

  always_comb begin
    nx = st;
    case (st)
      S_IDLE:  if (start) nx = S_ADDR;
      S_ADDR:  nx = S_LATCH;
      S_LATCH: nx = S_FLOAT;
      S_FLOAT: nx = S_DATA;
      S_DATA:  if (last) nx = S_REL;
      S_REL:   nx = S_IDLE;
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      wr_r     <= 1'b0;
      ext_r    <= 1'b0;
      wdata_r  <= '0;
      ack_o    <= 1'b0;
      rdata_o  <= '0;
      ad_out_o <= '0;
      ad_oe_o  <= 1'b0;
      as_n_o   <= 1'b1;
      ds_n_o   <= 1'b1;
      rw_o     <= 1'b1;
      dm_n_o   <= 1'b1;
    end else begin
      st     <= nx;
      as_n_o <= !(nx == S_ADDR);
      ds_n_o <= !(nx == S_DATA);
      ack_o  <= (st == S_REL);

      if (start) begin
        wr_r     <= wr_i;
        ext_r    <= ext_i;
        wdata_r  <= wdata_i;
        ad_out_o <= addr_i;
        rw_o     <= !wr_i;
        dm_n_o   <= !dmem_i;
      end else if (nx == S_IDLE) begin
        rw_o   <= 1'b1;
        dm_n_o <= 1'b1;
      end

      if (st == S_FLOAT) begin
        ad_out_o <= wdata_r;
        cnt      <= ext_r ? CW'(EXT_EXTRA) : '0;
      end else if (st == S_DATA && !last) begin
        cnt <= cnt - CW'(1);
      end

      case (nx)
        S_ADDR, S_LATCH: ad_oe_o <= 1'b1;
        S_DATA, S_REL:   ad_oe_o <= wr_r;
        default:         ad_oe_o <= 1'b0;
      endcase

      if (last && rw_o) rdata_o <= ad_in_i;
    end
  end

  a_r2_addr_held_at_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(as_n_o) |-> ad_oe_o && $stable(ad_out_o));

  a_r3_float_before_data: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ds_n_o) |-> !$past(ad_oe_o) && $past(as_n_o));

  a_r4_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_n_o |=> $stable(rw_o) && $stable(dm_n_o));

  a_r5_read_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_n_o && rw_o) |-> !ad_oe_o);

  a_r6_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_n_o && !rw_o) |-> ad_oe_o);

  a_r6_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ds_n_o) && !rw_o) |-> ad_oe_o && $stable(ad_out_o));

  a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!as_n_o && !ds_n_o));

endmodule

// File: tb/test_mux_bus_ctrl.sv
module test_mux_bus_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req, wr, dmem, ext;
  logic [7:0] addr, wdata, ad_in, rdata, ad_out;
  logic ack, ad_oe, as_n, ds_n, rw, dm_n;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_ctrl i_mux_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .dmem_i(dmem), .ext_i(ext),
    .addr_i(addr), .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata),
    .ad_out_o(ad_out), .ad_oe_o(ad_oe), .ad_in_i(ad_in), .as_n_o(as_n),
    .ds_n_o(ds_n), .rw_o(rw), .dm_n_o(dm_n)
  );

  // external memory model: two spaces of 256 bytes
  logic [7:0] mem [0:511];
  logic [7:0] ref_mem [0:511];
  logic [7:0] lat_addr = '0;
  logic       lat_sp = 1'b0;

  always @(posedge as_n) begin
    lat_addr = ad_out;
    lat_sp   = !dm_n;
  end
  always @(posedge ds_n) if (!rw) mem[{lat_sp, lat_addr}] = ad_out;
  assign ad_in = (!ds_n && rw) ? mem[{lat_sp, lat_addr}] : 8'h00;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic t_as [0:31], t_ds [0:31], t_oe [0:31], t_rw [0:31], t_dm [0:31], t_ack [0:31];
  logic [7:0] t_ad [0:31];

  task automatic xfer(input bit w, input bit d, input bit e, input logic [7:0] a, input logic [7:0] wd);
    int wid, kack, ds_cnt;
    bit ok;
    logic [7:0] exp_rd;
    wid  = e ? 3 : 1;
    kack = 0;
    exp_rd = ref_mem[{d, a}];
    @(negedge clk);
    req = 1'b1; wr = w; dmem = d; ext = e; addr = a; wdata = wd;
    for (int k = 1; k < 32; k++) begin
      @(negedge clk);
      if (k == 1) req = 1'b0;
      t_as[k] = as_n; t_ds[k] = ds_n; t_oe[k] = ad_oe; t_rw[k] = rw;
      t_dm[k] = dm_n; t_ack[k] = ack; t_ad[k] = ad_out;
      if (ack) begin kack = k; break; end
    end
    if (w) ref_mem[{d, a}] = wd;
    // R8: ack timing
    chk(kack == 5 + wid, "R8 ack clock", kack, 5 + wid);
    if (kack == 0) return;
    // R2: address phase
    chk(!t_as[1] && t_oe[1] && t_ad[1] == a && t_as[2] && t_oe[2] && t_ad[2] == a,
        "R2 address phase", t_ad[2], a);
    // R3: float clock
    chk(!t_oe[3] && t_as[3] && t_ds[3], "R3 float", t_oe[3], 0);
    // R7: strobe width and position
    ds_cnt = 0; ok = 1;
    for (int k = 1; k <= kack; k++) begin
      if (!t_ds[k]) ds_cnt++;
      if ((k >= 4 && k <= 3 + wid) == t_ds[k]) ok = 0;
    end
    chk(ok && ds_cnt == wid, "R7 data strobe width", ds_cnt, wid);
    // R4: direction and space select
    ok = 1;
    for (int k = 1; k <= 4 + wid; k++)
      if (t_rw[k] != !w || t_dm[k] != !d) ok = 0;
    chk(ok && t_rw[kack] && t_dm[kack], "R4 rw/dm hold", {t_rw[kack], t_dm[kack]}, 2'b11);
    // R9: no overlap
    ok = 1;
    for (int k = 1; k <= kack; k++) if (!t_as[k] && !t_ds[k]) ok = 0;
    chk(ok, "R9 strobe overlap", 0, 1);
    if (w) begin
      ok = 1;
      for (int k = 4; k <= 4 + wid; k++) if (!t_oe[k] || t_ad[k] != wd) ok = 0;
      chk(ok, "R6 write data window", t_ad[4], wd);
    end else begin
      ok = 1;
      for (int k = 4; k <= 3 + wid; k++) if (t_oe[k]) ok = 0;
      chk(ok, "R5 read undriven", 1, 0);
      chk(rdata == exp_rd, "R5 read data", rdata, exp_rd);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] alist [4];
    int first, second, n;
    alist = '{8'h00, 8'h5A, 8'hA5, 8'hFF};
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'(i) ^ ((i >= 256) ? 8'hA5 : 8'h3C);
      ref_mem[i] = mem[i];
    end
    req = 0; wr = 0; dmem = 0; ext = 0; addr = 0; wdata = 0;
    #(CLK_PERIOD * 3 + 1);
    // R1: reset state
    chk(as_n && ds_n && !ad_oe && !ack && rw && dm_n, "R1 reset state",
        {as_n, ds_n, ad_oe, ack, rw, dm_n}, 6'b110011);
    rst_n = 1'b1;
    for (int e = 0; e < 2; e++)
      for (int d = 0; d < 2; d++)
        for (int j = 0; j < 4; j++) begin
          xfer(0, d[0], e[0], alist[j], 8'h00);
          xfer(1, d[0], e[0], alist[j], alist[j] ^ 8'hC3 ^ 8'(e * 16 + d * 2 + j));
          xfer(0, d[0], e[0], alist[j], 8'h00);
        end
    // R10: back-to-back with request held
    for (int e = 0; e < 2; e++) begin
      @(negedge clk);
      req = 1'b1; wr = 1'b0; dmem = 1'b0; ext = e[0]; addr = 8'h11;
      first = -1; second = -1; n = 0;
      for (int k = 1; k < 40 && second < 0; k++) begin
        @(negedge clk);
        if (!as_n) begin
          if (first < 0) first = k; else if (k > first + 1) second = k;
        end
      end
      req = 1'b0;
      n = e ? 9 : 7;
      chk(second - first == n, "R10 restart spacing", second - first, n);
      repeat (12) @(negedge clk);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule